// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block watches the control strobes of an asynchronous DRAM bus (row strobe, column strobe, write enable and output enable, all active low) from a synchronous clock domain. It samples the strobes and the row address on every clock. From the order in which the strobes change it works out what kind of memory cycle the controller ran. When the row strobe returns high it reports the cycle type with a one-clock valid pulse. It serves as the front end of a device model or of a bus checker in a verification environment.

Alongside the classification it does three more jobs. It keeps the internal refresh row counter that a real device would step on each internally addressed refresh. It reports whether the device would be driving its data pins at that moment. It keeps a record of which rows were refreshed within each refresh window, and it raises a sticky violation flag when a window ends with any row left untouched. The strobes are expected to be already in the clock domain, or slow compared with the clock. Every strobe edge then spans at least one sample.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While reset is active and right after it, `cyc_type` is 0, `cyc_valid` is 0, `ref_row` is 0, `dq_drive` is 0 and `refresh_violation` is 0.
- R2: A cycle is reported one clock after the sample in which the row strobe is first seen high again. `cyc_valid` is high for exactly one clock. `cyc_type` holds the last code until the next report. The codes are: 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh, 7 write with indeterminate timing.
- R3: A row strobe fall with the column strobe high, then a column strobe fall with write enable high, and no later write-enable fall, is reported as code 1.
- R4: If write enable was already low in the sample before the column strobe fall and is still low at that fall, the cycle is reported as code 2, and `dq_drive` stays 0 throughout.
- R5: If write enable falls in the same sample as the column strobe, the cycle is reported as code 7.
- R6: If write enable falls after a column strobe fall that returned read data, the cycle is reported as code 3. `dq_drive` is 1 (with output enable low) from the column strobe fall up to the write-enable fall, and 0 from then on.
- R7: A row strobe pulse with no column strobe fall is reported as code 4, and `dq_drive` stays 0.
- R8: A row strobe fall while the column strobe is low, starting from an idle bus, is reported as code 5. `ref_row` advances by one in the same clock as the report, and `dq_drive` stays 0.
- R9: After a read whose column strobe stays low across the row strobe rise, a further row strobe pulse is reported as code 6. `ref_row` advances by one, and `dq_drive` keeps driving the earlier read data throughout.
- R10: `dq_drive` is 1 exactly while read data is held and output enable is sampled low. It drops one clock after the column strobe is sampled high or output enable is sampled high.
- R11: `ref_row` is ROW_W bits wide, steps only by one, wraps from its all-ones value to 0, and is cleared only by reset.
- R12: A normal access or a row-only refresh marks the row latched at the row strobe fall as refreshed. An internal refresh marks the row held in `ref_row` before it steps. Each REF_PERIOD clocks from reset form a window. If a window ends with any row unmarked, `refresh_violation` goes to 1 and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe pin level |
| cas_n | input | 1 | Column strobe pin level |
| we_n | input | 1 | Write enable pin level |
| oe_n | input | 1 | Output enable pin level |
| row_addr | input | ROW_W | Address pins, latched as the row at the row strobe fall |
| cyc_type | output | 3 | Code of the last cycle reported |
| cyc_valid | output | 1 | One-clock pulse when a cycle is reported |
| ref_row | output | ROW_W | Internal refresh row counter |
| dq_drive | output | 1 | Device would drive its data pins |
| refresh_violation | output | 1 | Sticky: some row went a whole window without refresh |

## Verification
The bench drives one cycle of each kind in turn. A read and an early write differ only in when write enable falls relative to the column strobe. The same-sample fall then separates the indeterminate code from both, and a late fall separates read-modify-write. A row-only pulse and a column-first refresh check that the column strobe level at the row fall selects an external or an internal row. A read that holds the column strobe low into a second row pulse tells hidden refresh apart from the column-first kind, by the counter step and by the data pins staying driven. The first window touches every row and the second leaves two rows out, which exercises both outcomes of the window check and the counter wrap.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;

    // bit positions of the sampled strobes inside the edge vectors
    localparam int STB_RAS = 0;
    localparam int STB_CAS = 1;
    localparam int STB_WE  = 2;
    localparam int STB_N   = 3;

    typedef enum logic [2:0] {
        CYC_NONE     = 3'd0,
        CYC_READ     = 3'd1,
        CYC_EWRITE   = 3'd2,
        CYC_RMW      = 3'd3,
        CYC_ROWONLY  = 3'd4,
        CYC_COLFIRST = 3'd5,
        CYC_HIDDEN   = 3'd6,
        CYC_WINDET   = 3'd7
    } cyc_code_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACCESS,
        PH_HOLD,
        PH_INTREF
    } phase_e;

endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        assign fall_o[i] = prev_q[i] & ~lvl_i[i];
        assign rise_o[i] = ~prev_q[i] & lvl_i[i];
    end

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dram_strobe_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_N-1:0] fall_i,
    input  logic [STB_N-1:0] rise_i,
    input  logic             cas_lvl_i,
    input  logic             we_lvl_i,
    input  logic             oe_lvl_i,
    input  logic [ROW_W-1:0] row_i,
    output cyc_code_e        code_o,
    output logic             valid_o,
    output logic             drive_o,
    output logic             mark_o,
    output logic             mark_int_o,
    output logic [ROW_W-1:0] mark_row_o,
    output logic             inc_o
);

    typedef struct packed {
        phase_e           ph;
        logic             hid;
        logic             casf;
        logic             ewr;
        logic             indet;
        logic             rmw;
        logic             rdata;
        logic             drive;
        logic             valid;
        cyc_code_e        code;
        logic [ROW_W-1:0] row;
    } cls_t;

    cls_t cls_d, cls_q;

    logic unused_edges;
    assign unused_edges = rise_i[STB_WE];

    always_comb begin
        cls_d       = cls_q;
        cls_d.valid = 1'b0;
        mark_o      = 1'b0;
        mark_int_o  = 1'b0;
        inc_o       = 1'b0;
        mark_row_o  = cls_q.row;
        unique case (cls_q.ph)
            PH_IDLE: begin
                if (fall_i[STB_RAS]) begin
                    if (!cas_lvl_i) begin
                        cls_d.ph  = PH_INTREF;
                        cls_d.hid = 1'b0;
                    end else begin
                        cls_d.ph    = PH_ACCESS;
                        cls_d.row   = row_i;
                        cls_d.casf  = 1'b0;
                        cls_d.ewr   = 1'b0;
                        cls_d.indet = 1'b0;
                        cls_d.rmw   = 1'b0;
                    end
                end
            end
            PH_ACCESS: begin
                if (fall_i[STB_CAS]) begin
                    cls_d.casf = 1'b1;
                    if (!we_lvl_i) begin
                        if (fall_i[STB_WE]) cls_d.indet = 1'b1;
                        else                cls_d.ewr   = 1'b1;
                    end else begin
                        cls_d.rdata = 1'b1;
                    end
                end else if (fall_i[STB_WE] && cls_q.rdata) begin
                    cls_d.rmw   = 1'b1;
                    cls_d.rdata = 1'b0;
                end
                if (rise_i[STB_RAS]) begin
                    cls_d.valid = 1'b1;
                    mark_o      = 1'b1;
                    if (!cls_d.casf)      cls_d.code = CYC_ROWONLY;
                    else if (cls_d.indet) cls_d.code = CYC_WINDET;
                    else if (cls_d.ewr)   cls_d.code = CYC_EWRITE;
                    else if (cls_d.rmw)   cls_d.code = CYC_RMW;
                    else                  cls_d.code = CYC_READ;
                    if (cls_d.code == CYC_READ && !cas_lvl_i) cls_d.ph = PH_HOLD;
                    else                                      cls_d.ph = PH_IDLE;
                end
            end
            PH_HOLD: begin
                if (rise_i[STB_CAS]) begin
                    cls_d.ph = PH_IDLE;
                end else if (fall_i[STB_RAS]) begin
                    cls_d.ph  = PH_INTREF;
                    cls_d.hid = 1'b1;
                end
            end
            PH_INTREF: begin
                if (rise_i[STB_RAS]) begin
                    cls_d.valid = 1'b1;
                    mark_o      = 1'b1;
                    mark_int_o  = 1'b1;
                    inc_o       = 1'b1;
                    cls_d.code  = cls_q.hid ? CYC_HIDDEN : CYC_COLFIRST;
                    if (cls_q.hid && !cas_lvl_i) cls_d.ph = PH_HOLD;
                    else                         cls_d.ph = PH_IDLE;
                end
            end
            default: cls_d.ph = PH_IDLE;
        endcase
        if (rise_i[STB_CAS]) cls_d.rdata = 1'b0;
        cls_d.drive = cls_d.rdata & ~oe_lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q <= '{ph: PH_IDLE, code: CYC_NONE, row: '0, default: 1'b0};
        end else begin
            cls_q <= cls_d;
        end
    end

    assign code_o  = cls_q.code;
    assign valid_o = cls_q.valid;
    assign drive_o = cls_q.drive;

    assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_ewrite_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_o == CYC_EWRITE) |-> !drive_o);

    assert_rowonly_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_o == CYC_ROWONLY) |-> !drive_o);

    assert_colfirst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_o == CYC_COLFIRST) |-> !drive_o);

    assert_hidden_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_o == CYC_HIDDEN && !$past(oe_lvl_i) && !$past(cas_lvl_i)) |-> drive_o);

endmodule

// File: rtl/dram_refresh_tracker.sv
module dram_refresh_tracker #(
    parameter int ROW_W      = 11,
    parameter int REF_PERIOD = 6_400_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_i,
    input  logic             mark_int_i,
    input  logic [ROW_W-1:0] mark_row_i,
    input  logic             inc_i,
    output logic [ROW_W-1:0] ctr_o,
    output logic             viol_o
);

    localparam int ROWS  = 1 << ROW_W;
    localparam int WIN_W = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(REF_PERIOD - 1);

    typedef struct packed {
        logic [ROW_W-1:0] ctr;
        logic [ROWS-1:0]  fresh;
        logic [WIN_W-1:0] win;
        logic             viol;
    } trk_t;

    trk_t trk_d, trk_q;

    logic [ROW_W-1:0] hit_row;
    logic [ROWS-1:0]  hit_vec;
    logic [ROWS-1:0]  fresh_now;

    assign hit_row = mark_int_i ? trk_q.ctr : mark_row_i;

    for (genvar r = 0; r < ROWS; r++) begin : g_hit
        assign hit_vec[r] = mark_i && (hit_row == ROW_W'(r));
    end

    assign fresh_now = trk_q.fresh | hit_vec;

    always_comb begin
        trk_d     = trk_q;
        trk_d.ctr = trk_q.ctr + ROW_W'(inc_i);
        if (trk_q.win == WIN_LAST) begin
            if (!(&fresh_now)) trk_d.viol = 1'b1;
            trk_d.fresh = '0;
            trk_d.win   = '0;
        end else begin
            trk_d.fresh = fresh_now;
            trk_d.win   = trk_q.win + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign ctr_o  = trk_q.ctr;
    assign viol_o = trk_q.viol;

    assert_ctr_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_o != $past(ctr_o)) |-> (ctr_o == ROW_W'($past(ctr_o) + 1'b1)));

    assert_ctr_moves_on_internal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !mark_int_i) |-> 1'b0);

    assert_violation_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> viol_o);

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dram_strobe_pkg::*;
#(
    parameter int ROW_W      = 11,
    parameter int REF_PERIOD = 6_400_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] row_addr,
    output logic [2:0]       cyc_type,
    output logic             cyc_valid,
    output logic [ROW_W-1:0] ref_row,
    output logic             dq_drive,
    output logic             refresh_violation
);

    logic [STB_N-1:0] stb_lvl;
    logic [STB_N-1:0] stb_fall;
    logic [STB_N-1:0] stb_rise;
    cyc_code_e        code;
    logic             mark, mark_int, inc;
    logic [ROW_W-1:0] mark_row;

    always_comb begin
        stb_lvl          = '1;
        stb_lvl[STB_RAS] = ras_n;
        stb_lvl[STB_CAS] = cas_n;
        stb_lvl[STB_WE]  = we_n;
    end

    dram_strobe_sampler #(.N(STB_N)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (stb_lvl),
        .fall_o (stb_fall),
        .rise_o (stb_rise)
    );

    dram_cycle_classifier #(.ROW_W(ROW_W)) u_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (stb_fall),
        .rise_i     (stb_rise),
        .cas_lvl_i  (cas_n),
        .we_lvl_i   (we_n),
        .oe_lvl_i   (oe_n),
        .row_i      (row_addr),
        .code_o     (code),
        .valid_o    (cyc_valid),
        .drive_o    (dq_drive),
        .mark_o     (mark),
        .mark_int_o (mark_int),
        .mark_row_o (mark_row),
        .inc_o      (inc)
    );

    dram_refresh_tracker #(.ROW_W(ROW_W), .REF_PERIOD(REF_PERIOD)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark_i     (mark),
        .mark_int_i (mark_int),
        .mark_row_i (mark_row),
        .inc_i      (inc),
        .ctr_o      (ref_row),
        .viol_o     (refresh_violation)
    );

    assign cyc_type = code;

endmodule

// File: tb/dram_strobe_decoder_test.sv
`timescale 1ns/1ps
module dram_strobe_decoder_test;

    localparam int RW    = 3;
    localparam int NROWS = 1 << RW;
    localparam int PER   = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [RW-1:0] row_addr = '0;
    logic [2:0]    cyc_type;
    logic          cyc_valid;
    logic [RW-1:0] ref_row;
    logic          dq_drive;
    logic          refresh_violation;

    always #2.5 clk = ~clk;

    dram_strobe_decoder #(.ROW_W(RW), .REF_PERIOD(PER)) uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .row_addr(row_addr), .cyc_type(cyc_type), .cyc_valid(cyc_valid),
        .ref_row(ref_row), .dq_drive(dq_drive), .refresh_violation(refresh_violation)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc_cnt = 0;
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // behavioural reference, updated on each rising edge
    int  m_mode;             // 0 idle, 1 access, 2 held column, 3 internal refresh
    bit  m_pr, m_pc, m_pw;
    bit  m_hid, m_cf, m_ew, m_ind, m_rmw, m_rdata;
    int  m_row, m_ctr, m_type, m_win;
    bit  m_valid, m_drive, m_viol;
    bit  m_fresh [NROWS];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_pr = 1; m_pc = 1; m_pw = 1;
            m_hid = 0; m_cf = 0; m_ew = 0; m_ind = 0; m_rmw = 0; m_rdata = 0;
            m_row = 0; m_ctr = 0; m_type = 0; m_win = 0;
            m_valid = 0; m_drive = 0; m_viol = 0;
            foreach (m_fresh[i]) m_fresh[i] = 0;
        end else begin
            bit rf, rr, cf, cr, wf;
            int hit;
            cyc_cnt++;
            rf = m_pr && !ras_n; rr = !m_pr && ras_n;
            cf = m_pc && !cas_n; cr = !m_pc && cas_n;
            wf = m_pw && !we_n;
            m_valid = 0;
            hit = -1;
            if (m_mode == 0) begin
                if (rf) begin
                    if (!cas_n) begin m_mode = 3; m_hid = 0; end
                    else begin
                        m_mode = 1; m_row = int'(row_addr);
                        m_cf = 0; m_ew = 0; m_ind = 0; m_rmw = 0;
                    end
                end
            end else if (m_mode == 1) begin
                if (cf) begin
                    m_cf = 1;
                    if (!we_n) begin
                        if (wf) m_ind = 1; else m_ew = 1;
                    end else m_rdata = 1;
                end else if (wf && m_rdata) begin
                    m_rmw = 1; m_rdata = 0;
                end
                if (rr) begin
                    m_valid = 1;
                    m_type = !m_cf ? 4 : m_ind ? 7 : m_ew ? 2 : m_rmw ? 3 : 1;
                    hit = m_row;
                    m_mode = (m_type == 1 && !cas_n) ? 2 : 0;
                end
            end else if (m_mode == 2) begin
                if (cr) m_mode = 0;
                else if (rf) begin m_mode = 3; m_hid = 1; end
            end else begin
                if (rr) begin
                    m_valid = 1;
                    m_type = m_hid ? 6 : 5;
                    hit = m_ctr;
                    m_ctr = (m_ctr + 1) % NROWS;
                    m_mode = (m_hid && !cas_n) ? 2 : 0;
                end
            end
            if (cr) m_rdata = 0;
            m_drive = m_rdata && !oe_n;
            if (hit >= 0) m_fresh[hit] = 1;
            if (m_win == PER - 1) begin
                foreach (m_fresh[i]) if (!m_fresh[i]) m_viol = 1;
                foreach (m_fresh[i]) m_fresh[i] = 0;
                m_win = 0;
            end else m_win++;
            m_pr = ras_n; m_pc = cas_n; m_pw = we_n;
        end
    end

    // compare against the reference every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check("R2 model type",       cyc_type,          m_type);
            check("R2 model valid",      cyc_valid,         m_valid);
            check("R11 model counter",   ref_row,           m_ctr);
            check("R10 model drive",     dq_drive,          m_drive);
            check("R12 model violation", refresh_violation, m_viol);
        end
    end

    task automatic cyc(input bit r, input bit c, input bit w, input bit o, input int a);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; row_addr = RW'(a);
        @(posedge clk);
        #1;
    endtask

    task automatic idle_until(input int n);
        while (cyc_cnt < n) cyc(1, 1, 1, 0, 0);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 type",      cyc_type, 0);
        check("R1 valid",     cyc_valid, 0);
        check("R1 counter",   ref_row, 0);
        check("R1 drive",     dq_drive, 0);
        check("R1 violation", refresh_violation, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 1, 0, 0);
        check("R1 after release type", cyc_type, 0);

        // read of row 1
        cyc(0, 1, 1, 0, 1);
        cyc(0, 0, 1, 0, 0);
        check("R10 read drives", dq_drive, 1);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 1, 1, 0, 0);
        check("R3 read code", cyc_type, 1);
        check("R2 valid pulse", cyc_valid, 1);
        check("R10 drive off after column rise", dq_drive, 0);
        cyc(1, 1, 1, 0, 0);
        check("R2 valid single", cyc_valid, 0);
        check("R2 code held", cyc_type, 1);

        // early write of row 2
        cyc(0, 1, 1, 0, 2);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        check("R4 no drive", dq_drive, 0);
        cyc(1, 1, 1, 0, 0);
        check("R4 early write code", cyc_type, 2);
        check("R4 no drive at end", dq_drive, 0);

        // coincident write enable and column fall, row 3
        cyc(0, 1, 1, 0, 3);
        cyc(0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 0);
        check("R5 indeterminate code", cyc_type, 7);

        // read-modify-write of row 4
        cyc(0, 1, 1, 0, 4);
        cyc(0, 0, 1, 0, 0);
        check("R6 read phase drives", dq_drive, 1);
        cyc(0, 0, 0, 0, 0);
        check("R6 write phase off", dq_drive, 0);
        cyc(1, 1, 1, 0, 0);
        check("R6 rmw code", cyc_type, 3);

        // row-only refresh of row 5
        cyc(0, 1, 1, 0, 5);
        cyc(0, 1, 1, 0, 0);
        cyc(1, 1, 1, 0, 0);
        check("R7 row-only code", cyc_type, 4);
        check("R7 no drive", dq_drive, 0);
        check("R7 counter untouched", ref_row, 0);

        // column-first refresh, internal row 0
        cyc(1, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0);
        check("R8 column-first code", cyc_type, 5);
        check("R8 counter step", ref_row, 1);
        check("R8 no drive", dq_drive, 0);
        cyc(1, 1, 1, 0, 0);

        // read of row 6 followed by hidden refresh of internal row 1
        cyc(0, 1, 1, 0, 6);
        cyc(0, 0, 1, 0, 0);
        cyc(1, 0, 1, 0, 0);
        check("R3 read before hidden", cyc_type, 1);
        check("R9 drive held", dq_drive, 1);
        cyc(0, 0, 1, 0, 0);
        check("R9 drive during refresh", dq_drive, 1);
        cyc(1, 0, 1, 0, 0);
        check("R9 hidden code", cyc_type, 6);
        check("R9 counter step", ref_row, 2);
        check("R9 drive kept", dq_drive, 1);
        cyc(1, 0, 1, 1, 0);
        check("R10 output enable high", dq_drive, 0);
        cyc(1, 1, 1, 0, 0);

        // row-only refresh of row 7 completes the first window
        cyc(0, 1, 1, 0, 7);
        cyc(1, 1, 1, 0, 0);
        check("R7 row-only code again", cyc_type, 4);

        idle_until(PER + 10);
        check("R12 full window clean", refresh_violation, 0);

        // six internal refreshes: rows 2..7, counter wraps to 0
        for (int k = 0; k < 6; k++) begin
            cyc(1, 0, 1, 0, 0);
            cyc(0, 0, 1, 0, 0);
            cyc(1, 0, 1, 0, 0);
            check("R11 counter step", ref_row, (3 + k) % NROWS);
            cyc(1, 1, 1, 0, 0);
        end
        check("R11 wrapped to zero", ref_row, 0);

        idle_until(2 * PER + 10);
        check("R12 missed rows flagged", refresh_violation, 1);
        idle_until(2 * PER + 20);
        check("R12 flag sticky", refresh_violation, 1);

        done = 1;
        summary();
        $finish;
    end

endmodule